// File: doc/BRIEF.md
# Oversampled Byte Transmitter

The block sends bytes taken from a small transmit queue out on a single serial line. An external enable strobe, pulsed at eight times the baud rate, paces it. Every bit on the line lasts exactly eight of these strobes. A frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit. Between frames the line rests at the high level.

The block has two line modes. In push-pull mode the driver is always enabled and the output level carries the bit. In open-drain mode, used when one wire is shared, the output level stays at 0 and the bit steers the driver enable instead. A 0 bit enables the driver and pulls the line low. A 1 bit releases the line to its pull-up.

Software-side logic writes words into the queue. It watches the full and empty flags and uses the busy output to learn when the last stop bit has left the line. A restart input returns the sequencer to its wait-for-data state. Words already queued are kept.

Top module: `uart_ovs_tx`

## Requirements
- R1: After reset, empty_o=1, full_o=0 and busy_o=0, and the line rests idle-high (push-pull: line_o=1, line_oe_o=1).
- R2: Every bit of a frame lasts exactly 8 clock cycles that have tick_i=1. With tick_i held high, a word written into an empty queue while idle starts its start bit on the second clock edge after the write, and that start bit lasts exactly 8 cycles.
- R3: A frame is a 0 start bit, then data bits 0..7 in that order (LSB first), then a 1 stop bit.
- R4: The stop level lasts at least 8 ticks. When the next word is already queued, the next start bit follows the 8 stop ticks after one further idle-high cycle.
- R5: Only bits [7:0] of wr_data_i are sent. Bits [31:8] have no effect on the line.
- R6: The queue holds 8 words. full_o=1 when it holds 8, and a write while full_o=1 is dropped and never sent.
- R7: busy_o goes high on the edge that takes a word from the queue and falls on the edge that ends the 8th stop tick. empty_o can be 1 while busy_o is still 1.
- R8: With od_mode_i=1, line_o is always 0 and line_oe_o is the inverse of the bit level: 1 for a 0 bit, 0 for a 1 bit and while idle.
- R9: With od_mode_i=0, line_oe_o is always 1 and line_o carries the bit level.
- R10: restart_i=1 makes the next cycle idle (busy_o=0, line idle-high). Words still queued are kept and sent afterwards.
- R11: While tick_i=0 the sequencer does not advance, and the current bit level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample strobe, 8 per bit |
| restart_i | input | 1 | Synchronous return to wait-for-data |
| od_mode_i | input | 1 | 1 = open-drain single-wire, 0 = push-pull |
| wr_en_i | input | 1 | Queue write strobe |
| wr_data_i | input | 32 | Queue write word, low byte used |
| full_o | output | 1 | Queue holds 8 words |
| empty_o | output | 1 | Queue holds no word |
| busy_o | output | 1 | Frame in progress |
| line_o | output | 1 | Line output level |
| line_oe_o | output | 1 | Line driver enable |

## Verification
When a word is written into an empty queue on an idle block, the pop happens on the next edge. The start level is visible from the second edge after the write. With the strobe held high, each later bit boundary falls exactly 8 cycles later. busy_o drops 80 cycles after the pop. The exact-timing scenarios sample every cycle on the falling clock edge and compare each sample against these cycle counts. The divided-strobe scenarios sample each bit at its middle, so a strobe phase offset of up to one divider period cannot move a sample across a bit boundary. Restart is checked one cycle after it is applied, and a back-to-back frame is checked at cycle 81 after the first start.

// File: rtl/uart_ovs_tx_pkg.sv
package uart_ovs_tx_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_ovs_tx_fifo.sv
module uart_ovs_tx_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push, pop;

  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign push      = wr_en_i && !full_o;
  assign pop       = rd_en_i && !empty_o;
  assign rd_data_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_ovs_tx_seq.sv
module uart_ovs_tx_seq
  import uart_ovs_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 8,  // >= 2
  parameter int unsigned DATA_BITS     = BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 restart_i,
  input  logic                 avail_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 pop_o,
  output logic                 busy_o,
  output logic                 level_o
);
  localparam int unsigned TICK_W = $clog2(TICKS_PER_BIT);
  localparam int unsigned BIT_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_BITS - 1);

  tx_state_e             state_q;
  logic [TICK_W-1:0]     tick_cnt_q;
  logic [BIT_W-1:0]      bit_cnt_q;
  logic [DATA_BITS-1:0]  shreg_q;
  logic                  bit_end;

  assign pop_o   = (state_q == ST_IDLE) && avail_i && !restart_i;
  assign busy_o  = (state_q != ST_IDLE);
  assign bit_end = tick_i && (tick_cnt_q == TICK_LAST);

  always_comb begin
    unique case (state_q)
      ST_START: level_o = 1'b0;
      ST_DATA:  level_o = shreg_q[0];
      default:  level_o = 1'b1;  // idle and stop rest high
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tick_cnt_q <= '0;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
    end else if (restart_i) begin
      state_q    <= ST_IDLE;
      tick_cnt_q <= '0;
      bit_cnt_q  <= '0;
    end else begin
      if (state_q == ST_IDLE) begin
        tick_cnt_q <= '0;
        bit_cnt_q  <= '0;
        if (avail_i) begin
          shreg_q <= data_i;
          state_q <= ST_START;
        end
      end else if (tick_i) begin
        tick_cnt_q <= bit_end ? '0 : tick_cnt_q + 1'b1;
      end

      if (bit_end) begin
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (bit_cnt_q == BIT_LAST) begin
              bit_cnt_q <= '0;
              state_q   <= ST_STOP;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_STOP: state_q <= ST_IDLE;
          default: state_q <= state_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_ovs_tx_drv.sv
module uart_ovs_tx_drv (
  input  logic level_i,
  input  logic od_mode_i,
  output logic line_o,
  output logic line_oe_o
);
  // open-drain: level steers the enable, driven value is always low
  assign line_o    = od_mode_i ? 1'b0 : level_i;
  assign line_oe_o = od_mode_i ? !level_i : 1'b1;
endmodule

// File: rtl/uart_ovs_tx.sv
module uart_ovs_tx
  import uart_ovs_tx_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned FIFO_DEPTH    = 8,
  parameter int unsigned TICKS_PER_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic              od_mode_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              busy_o,
  output logic              line_o,
  output logic              line_oe_o
);
  logic [BYTE_W-1:0] q_data;
  logic              pop, level;

  if (DATA_W > BYTE_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^wr_data_i[DATA_W-1:BYTE_W];
  end

  uart_ovs_tx_fifo #(
    .WIDTH (BYTE_W),
    .DEPTH (FIFO_DEPTH)
  ) fifo_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i[BYTE_W-1:0]),
    .rd_en_i   (pop),
    .rd_data_o (q_data),
    .full_o    (full_o),
    .empty_o   (empty_o)
  );

  uart_ovs_tx_seq #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .DATA_BITS     (BYTE_W)
  ) seq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (restart_i),
    .avail_i   (!empty_o),
    .data_i    (q_data),
    .pop_o     (pop),
    .busy_o    (busy_o),
    .level_o   (level)
  );

  uart_ovs_tx_drv drv_i (
    .level_i   (level),
    .od_mode_i (od_mode_i),
    .line_o    (line_o),
    .line_oe_o (line_oe_o)
  );
endmodule

// File: rtl/uart_ovs_tx_chk.sv
module uart_ovs_tx_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              restart_i,
  input logic              od_mode_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              full_o,
  input logic              empty_o,
  input logic              busy_o,
  input logic              line_o,
  input logic              line_oe_o
);
  logic unused_in;
  assign unused_in = wr_en_i ^ (^wr_data_i);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !empty_o);

  // R7
  busy_after_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!empty_o));

  // R8
  od_idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_mode_i && !busy_o) |-> (!line_oe_o && !line_o));

  // R9
  pp_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!od_mode_i && !busy_o) |-> (line_o && line_oe_o));

  // R10
  restart_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !busy_o);

  // R11
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !restart_i) |=> busy_o);
endmodule

bind uart_ovs_tx uart_ovs_tx_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/uart_ovs_tx_tb_top.sv
module uart_ovs_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        restart = 1'b0;
  logic        od_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        full, empty, busy, line, line_oe;

  int chk_n = 0;
  int fail_n = 0;
  int tick_div = 1;
  int tcnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_ovs_tx dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .restart_i (restart),
    .od_mode_i (od_mode),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .full_o    (full),
    .empty_o   (empty),
    .busy_o    (busy),
    .line_o    (line),
    .line_oe_o (line_oe)
  );

  // strobe generator: 0 = off, 1 = every cycle, n = one in n
  always @(negedge clk) begin
    if (tick_div == 0) tick = 1'b0;
    else if (tcnt >= tick_div - 1) begin tick = 1'b1; tcnt = 0; end
    else begin tick = 1'b0; tcnt++; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic eff_level();
    return od_mode ? ~line_oe : line;
  endfunction

  task automatic push(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rx_frame(input int div, input logic [7:0] exp, input string tag);
    bit found = 0;
    bit od_ok = 1;
    int t = 0;
    logic [9:0] bits;
    for (int i = 0; i < 4000 && !found; i++) begin
      @(negedge clk);
      if (eff_level() == 1'b0) found = 1;
    end
    check(found, {tag, " start seen"}, found, 1);
    if (found) begin
      for (int k = 0; k < 10; k++) begin
        while (t < 8*div*k + 4*div) begin
          @(negedge clk); t++;
          if (od_mode && line) od_ok = 0;
        end
        bits[k] = eff_level();
      end
      check(bits[0] == 1'b0, {tag, " start bit"}, bits[0], 0);
      check(bits[8:1] == exp, {tag, " data"}, bits[8:1], exp);
      check(bits[9] == 1'b1, {tag, " stop bit"}, bits[9], 1);
      if (od_mode) check(od_ok, {tag, " R8 line_o low in od mode"}, od_ok, 1);
      for (int i = 0; i < 40*div && busy; i++) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(empty == 1'b1 && full == 1'b0, "R1 flags after reset", {full, empty}, 2'b01);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(line == 1'b1 && line_oe == 1'b1, "R1 line idle-high", {line, line_oe}, 2'b11);
  endtask

  task automatic t_exact();
    logic lv [81];
    logic bz [81];
    logic oe_all = 1'b1;
    logic em0;
    logic [7:0] d = 8'hA5;
    bit ok_st = 1, ok_dat = 1, ok_sp = 1, ok_bz = 1;
    tick_div = 1;
    push({24'h0, d});
    for (int i = 0; i < 81; i++) begin
      @(negedge clk);
      lv[i] = line; bz[i] = busy;
      if (!line_oe) oe_all = 1'b0;
      if (i == 0) em0 = empty;
    end
    for (int i = 0; i < 8; i++) if (lv[i] !== 1'b0) ok_st = 0;
    for (int b = 0; b < 8; b++)
      for (int j = 0; j < 8; j++) if (lv[8+8*b+j] !== d[b]) ok_dat = 0;
    for (int i = 72; i < 81; i++) if (lv[i] !== 1'b1) ok_sp = 0;
    for (int i = 0; i < 80; i++) if (bz[i] !== 1'b1) ok_bz = 0;
    check(ok_st, "R2 start low exactly 8 cycles", ok_st, 1);
    check(ok_dat, "R3 data LSB first, 8 cycles each", ok_dat, 1);
    check(ok_sp, "R3 stop high", ok_sp, 1);
    check(ok_bz, "R7 busy through stop", ok_bz, 1);
    check(bz[80] == 1'b0, "R7 busy falls after 8 stop ticks", bz[80], 0);
    check(em0 == 1'b1, "R7 empty while busy", em0, 1);
    check(oe_all == 1'b1, "R9 oe held in push-pull", oe_all, 1);
  endtask

  task automatic t_b2b();
    logic lv [170];
    logic [7:0] x = 8'h0F, y = 8'hF0;
    bit ok_gap = 1, ok_st = 1, ok_y = 1;
    tick_div = 1;
    @(negedge clk); wr_en = 1'b1; wr_data = {24'h0, x};
    @(negedge clk); wr_data = {24'h0, y};
    @(negedge clk); wr_en = 1'b0;
    lv[0] = line;
    for (int i = 1; i < 170; i++) begin @(negedge clk); lv[i] = line; end
    for (int i = 72; i < 81; i++) if (lv[i] !== 1'b1) ok_gap = 0;
    for (int i = 81; i < 89; i++) if (lv[i] !== 1'b0) ok_st = 0;
    for (int b = 0; b < 8; b++) if (lv[89+8*b+4] !== y[b]) ok_y = 0;
    check(ok_gap, "R4 stop 8 ticks plus one idle cycle", ok_gap, 1);
    check(ok_st, "R4 next start at cycle 81", ok_st, 1);
    check(ok_y, "R4 second frame data", ok_y, 1);
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
  endtask

  task automatic t_full();
    bit quiet = 1;
    bit held = 1;
    tick_div = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_data = {24'h0, 8'(8'h10 + i)};
    end
    @(negedge clk); wr_en = 1'b0;
    check(full == 1'b1 && empty == 1'b0, "R6 full after 8 queued", {full, empty}, 2'b10);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (line !== 1'b0 || !busy) held = 0; end
    check(held, "R11 start held without ticks", held, 1);
    tick_div = 1;
    for (int i = 0; i < 9; i++) rx_frame(1, 8'(8'h10 + i), "R6 queued word");
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (line !== 1'b1) quiet = 0; end
    check(quiet && empty && !busy, "R6 write while full dropped", {quiet, empty, busy}, 3'b110);
  endtask

  task automatic t_upper();
    tick_div = 3;
    push(32'hA5A5_5A3C);
    rx_frame(3, 8'h3C, "R5 upper bits ignored");
  endtask

  task automatic t_patterns();
    logic [7:0] pat [4] = '{8'h01, 8'h80, 8'hFF, 8'h00};
    tick_div = 3;
    for (int i = 0; i < 4; i++) begin
      push({24'hFFFFFF, pat[i]});
      rx_frame(3, pat[i], "R3 pattern div3");
    end
  endtask

  task automatic t_od();
    @(negedge clk); od_mode = 1'b1;
    @(negedge clk);
    check(line == 1'b0 && line_oe == 1'b0, "R8 od idle released", {line, line_oe}, 2'b00);
    tick_div = 1;
    push(32'h0000_003C);
    rx_frame(1, 8'h3C, "R8 od frame");
    push(32'h0000_00C3);
    @(negedge clk);
    check(line_oe == 1'b1 && line == 1'b0, "R8 od start drives low", {line, line_oe}, 2'b01);
    rx_frame(1, 8'hC3, "R8 od frame 2");
    @(negedge clk); od_mode = 1'b0;
  endtask

  task automatic t_restart();
    tick_div = 0;
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h0000_0066;
    @(negedge clk); wr_data = 32'h0000_0099;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check(line == 1'b0 && busy == 1'b1, "R10 frame in progress before restart", {line, busy}, 2'b01);
    restart = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && line == 1'b1, "R10 idle after restart", {busy, line}, 2'b01);
    restart = 1'b0;
    @(negedge clk);
    tick_div = 2;
    rx_frame(2, 8'h99, "R10 queued word kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exact();
    t_b2b();
    t_full();
    t_upper();
    t_patterns();
    t_od();
    t_restart();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", chk_n - fail_n, chk_n);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk_n++; fail_n++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", chk_n - fail_n, chk_n);
      $finish;
    end
  end
endmodule